// File: doc/BRIEF.md
# Fixed-Point DSP ALU with Local Register File

This block is the fixed-point arithmetic unit of a DSP coprocessor, together with the eight 32-bit registers it reads and writes. Each cycle, one instruction line may issue an ALU operation and a memory-load writeback at the same time. The ALU picks its first operand from the accumulator and X registers and its second from the Y and M registers. It computes one of nine operations and writes the result to any of the eight registers at the next clock edge. Chained add and subtract operations use a single carry/borrow flag, and the compare operation also writes that flag.

The load port writes data that arrived from memory on the same line. The ALU never sees that data. It always works on the register contents from before the line. The load write is committed at the same edge as the ALU write, and it wins when both target the same register. Copy, absolute value and negate replace the second operand with zero. Clear replaces both operands with zero. A combinational read port exposes any register to the surrounding datapath.

Top module: `dsp_alu_core`

## Requirements
- R1: After reset every register holds zero and the flag is 0.
- R2: Register index encoding: 0=A0, 1=A1, 2=X0, 3=X1, 4=Y0, 5=Y1, 6=M0, 7=M1. Source 1 selector value s picks index s. Source 2 selector value s picks index 4+s. The destination and load selectors take the index directly.
- R3: Operation code 0 (add) writes src1+src2 modulo 2^32 and sets the flag to the carry out of bit 31. Code 1 (subtract) writes src1-src2 modulo 2^32 and sets the flag to the borrow (1 when src1 < src2 unsigned).
- R4: Code 2 (add with carry) writes src1+src2+flag and code 3 (subtract with borrow) writes src1-src2-flag. Each updates the flag from its own carry or borrow out of bit 31.
- R5: Code 4 (compare) sets the flag to 1 when src1 equals src2 and to 0 otherwise. It writes no register.
- R6: Code 5 (copy) writes src1. Code 6 (absolute value) writes src1 negated when bit 31 is set and src1 unchanged otherwise. Code 7 (negate) writes 0-src1. Negating or taking the absolute value of 0x80000000 gives 0x80000000. None of the three changes the flag.
- R7: Code 8 (clear) writes zero to the destination and leaves the flag unchanged.
- R8: When a load and an ALU operation share a line, the ALU operands are the register values from before that line. The loaded value is in its register after the edge.
- R9: When the ALU destination and the load destination are the same register, that register holds the loaded value after the edge.
- R10: With the ALU valid input low, or with codes 9 to 15, no register is written by the ALU and the flag is unchanged.
- R11: A write committed at a rising edge is visible on the read port, and on the flag output, right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_valid | input | 1 | An ALU operation is issued on this line |
| alu_op | input | 4 | Operation code |
| src1_sel | input | 2 | First source selector (A0, A1, X0, X1) |
| src2_sel | input | 2 | Second source selector (Y0, Y1, M0, M1) |
| dst_sel | input | 3 | ALU destination register index |
| ld_valid | input | 1 | A memory load writes back on this line |
| ld_dst | input | 3 | Load destination register index |
| ld_data | input | 32 | Loaded data |
| rd_sel | input | 3 | Read port register index |
| rd_data | output | 32 | Read port data |
| flag_out | output | 1 | Carry/borrow/compare flag |

## Verification
Any fault in the register state or the flag shows up on the read port or on the flag output in the cycle right after the faulty edge. The bench reads all eight registers and the flag after every instruction. A wrong carry or borrow stays hidden until a chained add or subtract uses it, and the random op mix makes that happen within a few lines. A write-ordering fault between the load and the ALU shows up only on lines where the two share a register, so directed lines cover those conflicts and the random stimulus makes them frequent.

// File: rtl/dsp_alu_pkg.sv
`timescale 1ns/1ps
package dsp_alu_pkg;
    localparam int unsigned DW     = 32;
    localparam int unsigned NREG   = 8;
    localparam int unsigned IDXW   = $clog2(NREG);
    localparam int unsigned SELW   = IDXW - 1;
    localparam int unsigned OPW    = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ADDC = 4'd2,
        OP_SUBC = 4'd3,
        OP_CMP  = 4'd4,
        OP_COPY = 4'd5,
        OP_ABS  = 4'd6,
        OP_NEG  = 4'd7,
        OP_CLR  = 4'd8
    } alu_op_e;

    typedef logic [NREG-1:0][DW-1:0] regfile_t;

    typedef struct packed {
        regfile_t rf;
        logic     flag;
    } core_state_t;
endpackage

// File: rtl/dsp_alu_opnd.sv
`timescale 1ns/1ps
module dsp_alu_opnd
    import dsp_alu_pkg::*;
(
    input  regfile_t             rf,
    input  logic [OPW-1:0]       op,
    input  logic [SELW-1:0]      src1_sel,
    input  logic [SELW-1:0]      src2_sel,
    output logic [DW-1:0]        opa,
    output logic [DW-1:0]        opb
);
    logic [IDXW-1:0] idx_a;
    logic [IDXW-1:0] idx_b;

    always_comb begin
        idx_a = {1'b0, src1_sel};
        idx_b = {1'b1, src2_sel};
        opa   = rf[idx_a];
        opb   = rf[idx_b];
        case (op)
            OP_COPY, OP_ABS, OP_NEG: opb = '0;
            OP_CLR: begin
                opa = '0;
                opb = '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dsp_alu_arith.sv
`timescale 1ns/1ps
module dsp_alu_arith
    import dsp_alu_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    input  logic           flag_in,
    output logic [DW-1:0]  res,
    output logic           res_we,
    output logic           flag_nx,
    output logic           flag_we
);
    logic [DW:0] sum_w;
    logic [DW:0] dif_w;
    logic [DW:0] neg_w;
    logic        cin;

    always_comb begin
        cin   = (op == OP_ADDC || op == OP_SUBC) ? flag_in : 1'b0;
        sum_w = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, cin};
        dif_w = {1'b0, opa} - {1'b0, opb} - {{DW{1'b0}}, cin};
        neg_w = {1'b0, opb} - {1'b0, opa};
        res     = sum_w[DW-1:0];
        res_we  = 1'b0;
        flag_nx = flag_in;
        flag_we = 1'b0;
        case (op)
            OP_ADD, OP_ADDC: begin
                res_we  = 1'b1;
                flag_nx = sum_w[DW];
                flag_we = 1'b1;
            end
            OP_SUB, OP_SUBC: begin
                res     = dif_w[DW-1:0];
                res_we  = 1'b1;
                flag_nx = dif_w[DW];
                flag_we = 1'b1;
            end
            OP_CMP: begin
                flag_nx = (dif_w[DW-1:0] == '0);
                flag_we = 1'b1;
            end
            OP_COPY, OP_CLR: res_we = 1'b1;
            OP_ABS: begin
                res    = opa[DW-1] ? neg_w[DW-1:0] : sum_w[DW-1:0];
                res_we = 1'b1;
            end
            OP_NEG: begin
                res    = neg_w[DW-1:0];
                res_we = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dsp_alu_core.sv
`timescale 1ns/1ps
module dsp_alu_core
    import dsp_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alu_valid,
    input  logic [3:0]      alu_op,
    input  logic [1:0]      src1_sel,
    input  logic [1:0]      src2_sel,
    input  logic [2:0]      dst_sel,
    input  logic            ld_valid,
    input  logic [2:0]      ld_dst,
    input  logic [31:0]     ld_data,
    input  logic [2:0]      rd_sel,
    output logic [31:0]     rd_data,
    output logic            flag_out
);
    core_state_t   st_d, st_q;
    logic [DW-1:0] opa, opb, res;
    logic          res_we, flag_nx, flag_we;
    regfile_t      rf_view;

    dsp_alu_opnd u_opnd (
        .rf       (st_q.rf),
        .op       (alu_op),
        .src1_sel (src1_sel),
        .src2_sel (src2_sel),
        .opa      (opa),
        .opb      (opb)
    );

    dsp_alu_arith u_arith (
        .op      (alu_op),
        .opa     (opa),
        .opb     (opb),
        .flag_in (st_q.flag),
        .res     (res),
        .res_we  (res_we),
        .flag_nx (flag_nx),
        .flag_we (flag_we)
    );

    // ALU write first, load write last: the load wins on a shared destination.
    always_comb begin
        st_d = st_q;
        if (alu_valid && res_we)
            st_d.rf[dst_sel] = res;
        if (alu_valid && flag_we)
            st_d.flag = flag_nx;
        if (ld_valid)
            st_d.rf[ld_dst] = ld_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rf_view  = st_q.rf;
    assign rd_data  = st_q.rf[rd_sel];
    assign flag_out = st_q.flag;
endmodule

// File: rtl/dsp_alu_chk.sv
`timescale 1ns/1ps
module dsp_alu_chk
    import dsp_alu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        alu_valid,
    input logic [3:0]  alu_op,
    input logic [1:0]  src1_sel,
    input logic [1:0]  src2_sel,
    input logic [2:0]  dst_sel,
    input logic        ld_valid,
    input logic [2:0]  ld_dst,
    input logic [31:0] ld_data,
    input regfile_t    rf,
    input logic        flag
);
    logic ld_hits_dst;
    assign ld_hits_dst = ld_valid && (ld_dst == dst_sel);

    assert_load_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> rf[$past(ld_dst)] == $past(ld_data));

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && alu_op == 4'd8 && !ld_hits_dst) |=> rf[$past(dst_sel)] == '0);

    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && alu_op == 4'd4 && !ld_valid) |=> rf == $past(rf));

    assert_cmp_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && alu_op == 4'd4) |=>
            flag == ($past(rf[{1'b0, src1_sel}]) == $past(rf[{1'b1, src2_sel}])));

    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_valid || alu_op > 4'd4) |=> $stable(flag));

    assert_copy_old_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && alu_op == 4'd5 && !ld_hits_dst) |=>
            rf[$past(dst_sel)] == $past(rf[{1'b0, src1_sel}]));
endmodule

bind dsp_alu_core dsp_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alu_valid (alu_valid),
    .alu_op    (alu_op),
    .src1_sel  (src1_sel),
    .src2_sel  (src2_sel),
    .dst_sel   (dst_sel),
    .ld_valid  (ld_valid),
    .ld_dst    (ld_dst),
    .ld_data   (ld_data),
    .rf        (rf_view),
    .flag      (flag_out)
);

// File: tb/dsp_alu_core_bench.sv
`timescale 1ns/1ps
module dsp_alu_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alu_valid = 1'b0;
    logic [3:0]  alu_op = '0;
    logic [1:0]  src1_sel = '0;
    logic [1:0]  src2_sel = '0;
    logic [2:0]  dst_sel = '0;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_dst = '0;
    logic [31:0] ld_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        flag_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] m_rf [8];
    logic        m_flag;

    always #2 clk = ~clk;

    dsp_alu_core u_dsp_alu_core (
        .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_op(alu_op),
        .src1_sel(src1_sel), .src2_sel(src2_sel), .dst_sel(dst_sel),
        .ld_valid(ld_valid), .ld_dst(ld_dst), .ld_data(ld_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .flag_out(flag_out)
    );

    function automatic string req_of(input logic v, input logic [3:0] op);
        if (!v || op > 4'd8) return "R10";
        case (op)
            4'd0, 4'd1: return "R3";
            4'd2, 4'd3: return "R4";
            4'd4:       return "R5";
            4'd8:       return "R7";
            default:    return "R6";
        endcase
    endfunction

    // Expected next state from the requirements.
    task automatic model(input logic v, input logic [3:0] op, input logic [1:0] s1,
                         input logic [1:0] s2, input logic [2:0] d, input logic lv,
                         input logic [2:0] ldd, input logic [31:0] ldat);
        logic [31:0] a, b, r;
        logic [32:0] t;
        logic we, fwe, fn;
        a = m_rf[{1'b0, s1}];
        b = m_rf[{1'b1, s2}];
        r = '0; we = 1'b1; fwe = 1'b0; fn = m_flag;
        case (op)
            4'd0: begin t = {1'b0,a} + {1'b0,b}; r = t[31:0]; fn = t[32]; fwe = 1'b1; end
            4'd1: begin t = {1'b0,a} - {1'b0,b}; r = t[31:0]; fn = t[32]; fwe = 1'b1; end
            4'd2: begin t = {1'b0,a} + {1'b0,b} + {32'd0,m_flag}; r = t[31:0]; fn = t[32]; fwe = 1'b1; end
            4'd3: begin t = {1'b0,a} - {1'b0,b} - {32'd0,m_flag}; r = t[31:0]; fn = t[32]; fwe = 1'b1; end
            4'd4: begin we = 1'b0; fn = (a == b); fwe = 1'b1; end
            4'd5: r = a;
            4'd6: r = a[31] ? (32'd0 - a) : a;
            4'd7: r = 32'd0 - a;
            4'd8: r = 32'd0;
            default: we = 1'b0;
        endcase
        if (v && we) m_rf[d] = r;
        if (v && fwe) m_flag = fn;
        if (lv) m_rf[ldd] = ldat;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #0.1;
            n_checks++;
            if (rd_data !== m_rf[i]) begin
                n_fail++;
                $display("FAIL %s reg %0d actual %h expected %h", tag, i, rd_data, m_rf[i]);
            end
        end
        n_checks++;
        if (flag_out !== m_flag) begin
            n_fail++;
            $display("FAIL %s flag actual %b expected %b", tag, flag_out, m_flag);
        end
    endtask

    // Drive at the falling edge, commit at the rising edge, check at the next falling edge.
    task automatic step(input logic v, input logic [3:0] op, input logic [1:0] s1,
                        input logic [1:0] s2, input logic [2:0] d, input logic lv,
                        input logic [2:0] ldd, input logic [31:0] ldat, input string tag);
        alu_valid = v; alu_op = op; src1_sel = s1; src2_sel = s2; dst_sel = d;
        ld_valid = lv; ld_dst = ldd; ld_data = ldat;
        model(v, op, s1, s2, d, lv, ldd, ldat);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic load(input logic [2:0] d, input logic [31:0] x);
        step(1'b0, 4'd0, 2'd0, 2'd0, 3'd0, 1'b1, d, x, "R2");
    endtask

    initial begin
        #(4.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) m_rf[i] = '0;
        m_flag = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2 operand mapping: X1 (idx 3) + M0 (idx 6) -> Y1 (idx 5)
        load(3'd3, 32'h0000_0010);
        load(3'd6, 32'h0000_0005);
        step(1'b1, 4'd0, 2'd3, 2'd2, 3'd5, 1'b0, 3'd0, 32'd0, "R2");
        // R3 carry out of bit 31, borrow when src1 < src2
        load(3'd0, 32'hFFFF_FFFF);
        load(3'd4, 32'h0000_0001);
        step(1'b1, 4'd0, 2'd0, 2'd0, 3'd1, 1'b0, 3'd0, 32'd0, "R3");
        step(1'b1, 4'd1, 2'd1, 2'd0, 3'd2, 1'b0, 3'd0, 32'd0, "R3");
        // R4 chained add with carry and subtract with borrow
        step(1'b1, 4'd0, 2'd0, 2'd0, 3'd7, 1'b0, 3'd0, 32'd0, "R4");
        step(1'b1, 4'd2, 2'd0, 2'd0, 3'd7, 1'b0, 3'd0, 32'd0, "R4");
        step(1'b1, 4'd1, 2'd2, 2'd0, 3'd7, 1'b0, 3'd0, 32'd0, "R4");
        step(1'b1, 4'd3, 2'd2, 2'd0, 3'd7, 1'b0, 3'd0, 32'd0, "R4");
        // R5 compare equal and unequal
        load(3'd1, 32'h0000_0001);
        step(1'b1, 4'd4, 2'd1, 2'd0, 3'd1, 1'b0, 3'd0, 32'd0, "R5");
        step(1'b1, 4'd4, 2'd0, 2'd0, 3'd1, 1'b0, 3'd0, 32'd0, "R5");
        // R6 most negative value wraps under negate and absolute value
        load(3'd2, 32'h8000_0000);
        step(1'b1, 4'd7, 2'd2, 2'd0, 3'd4, 1'b0, 3'd0, 32'd0, "R6");
        step(1'b1, 4'd6, 2'd2, 2'd0, 3'd5, 1'b0, 3'd0, 32'd0, "R6");
        step(1'b1, 4'd6, 2'd0, 2'd0, 3'd5, 1'b0, 3'd0, 32'd0, "R6");
        // R7 clear
        step(1'b1, 4'd8, 2'd0, 2'd0, 3'd3, 1'b0, 3'd0, 32'd0, "R7");
        // R8 load into the ALU source on the same line: old value used
        step(1'b1, 4'd5, 2'd1, 2'd0, 3'd6, 1'b1, 3'd1, 32'hCAFE_0001, "R8");
        // R9 same destination: load wins
        step(1'b1, 4'd0, 2'd0, 2'd0, 3'd7, 1'b1, 3'd7, 32'h1234_5678, "R9");
        // R10 idle line and undefined code
        step(1'b0, 4'd8, 2'd0, 2'd0, 3'd7, 1'b0, 3'd0, 32'd0, "R10");
        step(1'b1, 4'd12, 2'd0, 2'd0, 3'd7, 1'b0, 3'd0, 32'd0, "R10");
        // R11 read port reflects a write right after the edge
        step(1'b1, 4'd5, 2'd3, 2'd0, 3'd0, 1'b0, 3'd0, 32'd0, "R11");

        for (int k = 0; k < 3000; k++) begin
            logic        v, lv;
            logic [3:0]  op;
            logic [2:0]  d, ldd;
            v   = ($urandom % 8) != 0;
            op  = 4'($urandom % 11);
            d   = 3'($urandom);
            lv  = ($urandom % 3) == 0;
            ldd = (($urandom % 2) == 0) ? d : 3'($urandom);
            step(v, op, 2'($urandom), 2'($urandom), d, lv, ldd,
                 (($urandom % 5) == 0) ? 32'h8000_0000 : $urandom, req_of(v, op));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule